// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a parallel host bus and the program/erase engine of a flash array. The host writes single-byte commands and their operands. The block decodes them and selects which source the read path presents: array data, identifier code, status byte or lock status. It starts, pauses, resumes and aborts the engine, and it keeps the eight-bit status byte that software polls. The engine itself is modelled as a cycle counter whose length is set separately for erase and for program. At completion the engine reports a failure and an over-program flag through two inputs.

Commands are taken from the low byte of each write. Erase is a two-step sequence, and the second step must be a confirm. Program loads a page of data writes before it starts. A running operation can be suspended so that other blocks can be read. A sleep request waits until the running operation has finished. The active-low power-down input resets the controller and aborts any operation that is running.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `pwr_dn_n` is low, and on the first cycle after it rises, the controller selects array reads (`rd_sel`=0). In that state `ready` is 1 and both the live and captured status bytes are 80h.
- R2: The read path is chosen by command: FFh selects array (`rd_sel`=0), 90h selects identifier (1), 70h selects status (2) and 71h selects lock status (3). An unknown byte leaves `rd_sel` unchanged.
- R3: `id_code` repeats one byte in every byte lane. With `rd_addr_lsb`=0 the byte is 1Ch. With `rd_addr_lsb`=1 it is 5Eh when BOTTOM_BOOT=1 and 5Dh otherwise.
- R4: Writing 20h then D0h starts an erase. `eng_start` is high for the single cycle after the confirm, with `eng_op`=0 and `eng_block` set to the confirm address shifted right by BLK_SHIFT. `ready` then stays 0 for exactly ERASE_CYCLES cycles, and `rd_sel` becomes 2.
- R5: Writing 41h followed by PAGE_WORDS data writes starts a program on the cycle after the last data write. `eng_op` is 1 and `eng_block` is taken from the last address. `ready` then stays 0 for exactly PROG_CYCLES cycles.
- R6: The status bits are: bit 7 ready, bit 6 suspended, bit 5 erase error, bit 4 program error, bit 3 over-programmed page, bit 0 sleeping. Bits 2 and 1 read 0.
- R7: When an erase ends with `eng_fail`=1, bit 5 is set. When a program ends with `eng_fail`=1, bit 4 is set; with `eng_ovp`=1, bit 3 is set. These bits survive every command except 50h, which clears all three.
- R8: If the write after 20h is not D0h, no operation starts. Bits 5 and 4 are both set, `ready` stays 1 and `rd_sel` is 2.
- R9: B0h written while busy sets `eng_suspend`, status bit 6 and `ready`, and freezes the engine count. FFh then selects array reads. D0h resumes for the remaining cycles only. A B0h that lands in the final busy cycle is ignored and the operation completes.
- R10: F0h written while idle sets status bit 0 at once. F0h written while busy sets it when the operation completes. While asleep every command except FFh is ignored, and FFh clears bit 0 and selects array reads.
- R11: Pulling `pwr_dn_n` low while an operation is running or suspended raises `eng_abort` for that cycle only. Afterwards the status byte returns to 80h and all error bits are cleared.
- R12: `status_out` changes only on a cycle with `rd_strobe`=1, when it takes the live status byte. Between strobes it holds its value.
- R13: Only `wr_data[7:0]` is decoded. The upper data byte has no effect; for example, A590h acts as 90h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_dn_n | input | 1 | Active-low reset/power-down, sampled on the clock |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; low byte carries the command |
| rd_strobe | input | 1 | Marks a new read access; captures the status byte |
| rd_addr_lsb | input | 1 | Read address bit 0, picks the identifier byte |
| eng_fail | input | 1 | Engine failure flag, sampled at completion |
| eng_ovp | input | 1 | Engine over-program flag, sampled at program completion |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status, 3 lock |
| id_code | output | DW | Identifier code for the current `rd_addr_lsb` |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_op | output | 1 | Operation kind: 0 erase, 1 program |
| eng_block | output | AW-BLK_SHIFT | Block index of the operation |
| eng_suspend | output | 1 | Engine held suspended |
| eng_abort | output | 1 | Engine abort, high while power-down hits a running operation |
| ready | output | 1 | 1 when no operation is running |
| status_out | output | 8 | Status byte captured at the last read strobe |

## Verification
Engine completion and a host command can land in the same cycle. This is most pointed when a suspend request arrives in the final busy cycle. The bench starts an erase, counts ERASE_CYCLES-1 cycles, and writes B0h so that it is registered on the very edge where the count expires. The result must be a finished operation: `ready` is 1, `eng_suspend` is 0 and status bit 6 is clear. A sleep request written during the busy period is also judged at completion, where bit 0 must appear together with bit 7.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    PATH_ARRAY  = 2'd0,
    PATH_IDENT  = 2'd1,
    PATH_STATUS = 2'd2,
    PATH_LOCK   = 2'd3
  } rd_path_e;

  typedef enum logic [3:0] {
    C_NONE, C_ARRAY, C_IDENT, C_STAT, C_LOCK, C_CLR,
    C_ERASE, C_PROG, C_SUSP, C_CONF, C_SLEEP
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERS_CFM, ST_PRG_LOAD, ST_BUSY, ST_SUSP
  } ctl_state_e;

  localparam int SB_READY = 7;
  localparam int SB_SUSP  = 6;
  localparam int SB_ERS   = 5;
  localparam int SB_PRG   = 4;
  localparam int SB_OVP   = 3;
  localparam int SB_SLEEP = 0;

  function automatic cmd_e decode_cmd(input logic [7:0] b);
    case (b)
      8'hFF:   return C_ARRAY;
      8'h90:   return C_IDENT;
      8'h70:   return C_STAT;
      8'h71:   return C_LOCK;
      8'h50:   return C_CLR;
      8'h20:   return C_ERASE;
      8'h41:   return C_PROG;
      8'hB0:   return C_SUSP;
      8'hD0:   return C_CONF;
      8'hF0:   return C_SLEEP;
      default: return C_NONE;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic sel_dev, input logic bottom);
    if (!sel_dev) return 8'h1C;
    return bottom ? 8'h5E : 8'h5D;
  endfunction

  function automatic logic [7:0] pack_status(input logic rdy, input logic susp,
                                             input logic ers, input logic prg,
                                             input logic ovp, input logic slp);
    logic [7:0] s;
    s = 8'h00;
    s[SB_READY] = rdy;
    s[SB_SUSP]  = susp;
    s[SB_ERS]   = ers;
    s[SB_PRG]   = prg;
    s[SB_OVP]   = ovp;
    s[SB_SLEEP] = slp;
    return s;
  endfunction

endpackage

// File: rtl/fcc_timer.sv
module fcc_timer #(
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 24
) (
  input  logic clk,
  input  logic pwr_dn_n,
  input  logic start,
  input  logic run,
  input  logic is_prog,
  output logic done
);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  function automatic logic [CW-1:0] final_count(input logic prog);
    return prog ? CW'(PROG_CYCLES - 1) : CW'(ERASE_CYCLES - 1);
  endfunction

  assign last = final_count(is_prog);
  assign done = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!pwr_dn_n)         cnt_q <= '0;
    else if (start)        cnt_q <= '0;
    else if (run && !done) cnt_q <= cnt_q + 1'b1;
  end

  // Count never passes the final value of the running operation (R4, R5)
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    run |-> cnt_q <= last);

endmodule

// File: rtl/fcc_status.sv
module fcc_status
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       pwr_dn_n,
  input  logic       ready,
  input  logic       susp,
  input  logic       sleep,
  input  logic       set_ers,
  input  logic       set_prg,
  input  logic       set_ovp,
  input  logic       clr_err,
  input  logic       rd_strobe,
  output logic [7:0] sr_live,
  output logic [7:0] sr_out
);
  logic ers_q, prg_q, ovp_q;

  always_ff @(posedge clk) begin
    if (!pwr_dn_n) begin
      ers_q <= 1'b0;
      prg_q <= 1'b0;
      ovp_q <= 1'b0;
    end else if (clr_err) begin
      ers_q <= 1'b0;
      prg_q <= 1'b0;
      ovp_q <= 1'b0;
    end else begin
      ers_q <= ers_q | set_ers;
      prg_q <= prg_q | set_prg;
      ovp_q <= ovp_q | set_ovp;
    end
  end

  assign sr_live = pack_status(ready, susp, ers_q, prg_q, ovp_q, sleep);

  always_ff @(posedge clk) begin
    if (!pwr_dn_n)      sr_out <= 8'h80;
    else if (rd_strobe) sr_out <= sr_live;
  end

  // Sticky error bits drop only through the clear command or power-down (R7)
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    ($fell(ers_q) || $fell(prg_q) || $fell(ovp_q)) |-> $past(clr_err || !pwr_dn_n));

  // Captured byte moves only on a strobe (R12)
  assert_capture_strobe_R12: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    !$past(rd_strobe) && $past(pwr_dn_n) |-> $stable(sr_out));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW           = 19,
  parameter int DW           = 16,
  parameter int BLK_SHIFT    = 15,
  parameter int PAGE_WORDS   = 128,
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 24,
  parameter bit BOTTOM_BOOT  = 1'b1
) (
  input  logic                    clk,
  input  logic                    pwr_dn_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    rd_strobe,
  input  logic                    rd_addr_lsb,
  input  logic                    eng_fail,
  input  logic                    eng_ovp,
  output logic [1:0]              rd_sel,
  output logic [DW-1:0]           id_code,
  output logic                    eng_start,
  output logic                    eng_op,
  output logic [AW-BLK_SHIFT-1:0] eng_block,
  output logic                    eng_suspend,
  output logic                    eng_abort,
  output logic                    ready,
  output logic [7:0]              status_out
);
  localparam int BLK_W = AW - BLK_SHIFT;
  localparam int LCW   = $clog2(PAGE_WORDS + 1);

  ctl_state_e     state_q;
  rd_path_e       path_q;
  logic [LCW-1:0] load_q;
  logic           sleep_q, sleep_pend_q, op_q;
  logic [BLK_W-1:0] blk_q;
  logic           start_q;

  // Named internal events
  cmd_e       cmd;
  logic       busy, done;
  logic       go_erase, go_prog, bad_cfm, do_susp, clr_cmd;
  logic       set_ers, set_prg, set_ovp;
  logic [7:0] sr_live;
  logic [BLK_W-1:0] addr_blk;

  function automatic logic [7:0] low_byte(input logic [DW-1:0] w);
    return w[7:0];
  endfunction

  assign cmd      = decode_cmd(low_byte(wr_data));
  assign addr_blk = BLK_W'(wr_addr >> BLK_SHIFT);
  assign busy     = (state_q == ST_BUSY);
  assign go_erase = wr_en && (state_q == ST_ERS_CFM) && (cmd == C_CONF);
  assign bad_cfm  = wr_en && (state_q == ST_ERS_CFM) && (cmd != C_CONF);
  assign go_prog  = wr_en && (state_q == ST_PRG_LOAD) && (load_q == LCW'(PAGE_WORDS - 1));
  assign do_susp  = wr_en && busy && !done && (cmd == C_SUSP);
  assign clr_cmd  = wr_en && (state_q == ST_IDLE) && !sleep_q && (cmd == C_CLR);
  assign set_ers  = (done && !op_q && eng_fail) || bad_cfm;
  assign set_prg  = (done && op_q && eng_fail) || bad_cfm;
  assign set_ovp  = done && op_q && eng_ovp;

  fcc_timer #(.ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .pwr_dn_n(pwr_dn_n), .start(go_erase || go_prog),
    .run(busy), .is_prog(op_q), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!pwr_dn_n) begin
      state_q      <= ST_IDLE;
      path_q       <= PATH_ARRAY;
      load_q       <= '0;
      sleep_q      <= 1'b0;
      sleep_pend_q <= 1'b0;
      op_q         <= 1'b0;
      blk_q        <= '0;
      start_q      <= 1'b0;
    end else begin
      start_q <= go_erase || go_prog;
      case (state_q)
        ST_IDLE: if (wr_en) begin
          if (sleep_q) begin
            if (cmd == C_ARRAY) begin
              sleep_q <= 1'b0;
              path_q  <= PATH_ARRAY;
            end
          end else begin
            case (cmd)
              C_ARRAY: path_q <= PATH_ARRAY;
              C_IDENT: path_q <= PATH_IDENT;
              C_STAT:  path_q <= PATH_STATUS;
              C_LOCK:  path_q <= PATH_LOCK;
              C_ERASE: begin state_q <= ST_ERS_CFM; path_q <= PATH_STATUS; end
              C_PROG:  begin state_q <= ST_PRG_LOAD; load_q <= '0; path_q <= PATH_STATUS; end
              C_SLEEP: sleep_q <= 1'b1;
              default: ;
            endcase
          end
        end
        ST_ERS_CFM: if (wr_en) begin
          path_q <= PATH_STATUS;
          if (go_erase) begin
            state_q <= ST_BUSY;
            op_q    <= 1'b0;
            blk_q   <= addr_blk;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_PRG_LOAD: if (wr_en) begin
          if (go_prog) begin
            state_q <= ST_BUSY;
            op_q    <= 1'b1;
            blk_q   <= addr_blk;
          end else begin
            load_q <= load_q + 1'b1;
          end
        end
        ST_BUSY: begin
          if (done) begin
            state_q      <= ST_IDLE;
            sleep_pend_q <= 1'b0;
            if (sleep_pend_q || (wr_en && cmd == C_SLEEP)) sleep_q <= 1'b1;
          end else if (wr_en) begin
            case (cmd)
              C_SUSP:  begin state_q <= ST_SUSP; path_q <= PATH_STATUS; end
              C_SLEEP: sleep_pend_q <= 1'b1;
              C_STAT:  path_q <= PATH_STATUS;
              default: ;
            endcase
          end
        end
        ST_SUSP: if (wr_en) begin
          case (cmd)
            C_ARRAY: path_q <= PATH_ARRAY;
            C_IDENT: path_q <= PATH_IDENT;
            C_STAT:  path_q <= PATH_STATUS;
            C_SLEEP: sleep_pend_q <= 1'b1;
            C_CONF:  begin state_q <= ST_BUSY; path_q <= PATH_STATUS; end
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fcc_status u_status (
    .clk(clk), .pwr_dn_n(pwr_dn_n), .ready(ready), .susp(eng_suspend),
    .sleep(sleep_q), .set_ers(set_ers), .set_prg(set_prg), .set_ovp(set_ovp),
    .clr_err(clr_cmd), .rd_strobe(rd_strobe), .sr_live(sr_live), .sr_out(status_out)
  );

  assign rd_sel      = path_q;
  assign id_code     = {(DW/8){id_byte(rd_addr_lsb, BOTTOM_BOOT)}};
  assign eng_start   = start_q;
  assign eng_op      = op_q;
  assign eng_block   = blk_q;
  assign eng_suspend = (state_q == ST_SUSP);
  assign ready       = !busy;
  assign eng_abort   = !pwr_dn_n && (state_q == ST_BUSY || state_q == ST_SUSP);

  // Start pulse always coincides with the first busy cycle (R4, R5)
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    eng_start |-> busy && !ready);

  // An accepted suspend parks the engine and reports ready plus bit 6 (R9)
  assert_suspend_ready_R9: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    do_susp |=> eng_suspend && ready && sr_live[SB_SUSP]);

  // Sleep never begins while an operation runs (R10)
  assert_sleep_idle_R10: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    $rose(sleep_q) |-> !busy && !eng_suspend);

  // Leaving power-down lands in array mode with status 80h (R1)
  assert_pd_exit_R1: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    $rose(pwr_dn_n) |-> sr_live == 8'h80 && rd_sel == PATH_ARRAY);

  // A failed confirm never starts the engine (R8)
  assert_badcfm_nostart_R8: assert property (@(posedge clk) disable iff (!pwr_dn_n)
    bad_cfm |=> !eng_start && ready);

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int AW = 19, DW = 16, BS = 15, PW = 128, EC = 40, PC = 24;

  logic          clk = 1'b0;
  logic          pwr_dn_n, wr_en, rd_strobe, rd_addr_lsb, eng_fail, eng_ovp;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0]    rd_sel;
  logic [DW-1:0] id_code;
  logic          eng_start, eng_op, eng_suspend, eng_abort, ready;
  logic [AW-BS-1:0] eng_block;
  logic [7:0]    status_out;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl dut (
    .clk(clk), .pwr_dn_n(pwr_dn_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_strobe(rd_strobe), .rd_addr_lsb(rd_addr_lsb),
    .eng_fail(eng_fail), .eng_ovp(eng_ovp), .rd_sel(rd_sel), .id_code(id_code),
    .eng_start(eng_start), .eng_op(eng_op), .eng_block(eng_block),
    .eng_suspend(eng_suspend), .eng_abort(eng_abort), .ready(ready),
    .status_out(status_out)
  );

  // {write data, expected rd_sel afterwards}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {16'h0090, 2'd1}, {16'h0070, 2'd2}, {16'h0071, 2'd3}, {16'h00FF, 2'd0},
    {16'hA590, 2'd1}, {16'h0012, 2'd1}, {16'hFF70, 2'd2}, {16'h5AFF, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    v = status_out;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int n;
    pwr_dn_n = 1'b0; wr_en = 1'b0; rd_strobe = 1'b0; rd_addr_lsb = 1'b0;
    eng_fail = 1'b0; eng_ovp = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    chk("R1 status in power-down", status_out, 8'h80);
    pwr_dn_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_sel after release", rd_sel, 0);
    chk("R1 ready after release", ready, 1);
    rd(s); chk("R1 status after release", s, 8'h80);

    // Mode selection table (R2, R13)
    for (int i = 0; i < NV; i++) begin
      wr('0, VEC[i][17:2]);
      chk("R2/R13 rd_sel from command", rd_sel, VEC[i][1:0]);
    end

    // Identifier (R3)
    wr('0, 16'h0090);
    rd_addr_lsb = 1'b0; #1;
    chk("R3 manufacturer code", id_code, 16'h1C1C);
    rd_addr_lsb = 1'b1; #1;
    chk("R3 device code", id_code, 16'h5E5E);
    wr('0, 16'h00FF);

    // Erase sequence and timing (R4, R6)
    wr('0, 16'h0020);
    chk("R4 status path after 20h", rd_sel, 2);
    wr(19'h4ABCD, 16'h00D0);
    chk("R4 start pulse", eng_start, 1);
    chk("R4 op is erase", eng_op, 0);
    chk("R4 block index", eng_block, 19'h4ABCD >> BS);
    busy_len(n);
    chk("R4 erase busy cycles", n, EC);
    rd(s); chk("R6 idle status", s, 8'h80);

    // Sticky erase error (R7)
    eng_fail = 1'b1;
    wr('0, 16'h0020); wr('0, 16'h00D0);
    busy_len(n);
    eng_fail = 1'b0;
    rd(s); chk("R7 erase error bit5", s, 8'hA0);
    wr('0, 16'h00FF); wr('0, 16'h0090);
    rd(s); chk("R7 error survives FFh/90h", s, 8'hA0);
    wr('0, 16'h0050);
    rd(s); chk("R7 clear by 50h", s, 8'h80);

    // Program page (R5, R7)
    eng_fail = 1'b1; eng_ovp = 1'b1;
    wr('0, 16'h0041);
    for (int i = 0; i < PW - 1; i++) wr(19'h12300 + AW'(i), 16'h1234);
    chk("R5 no start during load", eng_start, 0);
    wr(19'h12340, 16'h5678);
    chk("R5 start after last word", eng_start, 1);
    chk("R5 op is program", eng_op, 1);
    chk("R5 block index", eng_block, 19'h12340 >> BS);
    busy_len(n);
    chk("R5 program busy cycles", n, PC);
    eng_fail = 1'b0; eng_ovp = 1'b0;
    rd(s); chk("R7 program error and over-program", s, 8'h98);
    wr('0, 16'h0050);

    // Bad confirm (R8)
    wr('0, 16'h0020); wr('0, 16'h0033);
    chk("R8 no start", eng_start, 0);
    chk("R8 ready", ready, 1);
    chk("R8 status path", rd_sel, 2);
    rd(s); chk("R8 both error bits", s, 8'hB0);
    wr('0, 16'h0050);

    // Suspend and resume (R9)
    wr('0, 16'h0020); wr('0, 16'h00D0);
    repeat (10) @(negedge clk);
    wr('0, 16'h00B0);
    chk("R9 suspend output", eng_suspend, 1);
    chk("R9 ready while suspended", ready, 1);
    rd(s); chk("R9 suspended status", s, 8'hC0);
    wr('0, 16'h00FF);
    chk("R9 array read while suspended", rd_sel, 0);
    repeat (5) @(negedge clk);
    chk("R9 still suspended", eng_suspend, 1);
    wr('0, 16'h00D0);
    chk("R9 resumed", eng_suspend, 0);
    busy_len(n);
    chk("R9 remaining busy cycles", n, EC - 11);

    // Suspend landing on the completion cycle (R9)
    wr('0, 16'h0020); wr('0, 16'h00D0);
    repeat (EC - 1) @(negedge clk);
    wr('0, 16'h00B0);
    chk("R9 late suspend ignored: ready", ready, 1);
    chk("R9 late suspend ignored: suspend", eng_suspend, 0);
    rd(s); chk("R9 late suspend status", s, 8'h80);

    // Deferred and immediate sleep (R10, R12)
    wr('0, 16'h0020); wr('0, 16'h00D0);
    wr('0, 16'h00F0);
    chk("R12 stale capture while busy", status_out, 8'h80);
    rd(s); chk("R10 no sleep while busy", s, 8'h00);
    busy_len(n);
    chk("R12 capture held after finish", status_out, 8'h00);
    rd(s); chk("R10 sleep after completion", s, 8'h81);
    wr('0, 16'h0090);
    chk("R10 command ignored asleep", rd_sel, 2);
    wr('0, 16'h00FF);
    chk("R10 FFh wakes to array", rd_sel, 0);
    rd(s); chk("R10 sleep bit cleared", s, 8'h80);
    wr('0, 16'h00F0);
    rd(s); chk("R10 idle sleep immediate", s, 8'h81);
    wr('0, 16'h00FF);

    // Abort by power-down (R11)
    wr('0, 16'h0020); wr('0, 16'h0011);
    wr('0, 16'h0020); wr('0, 16'h00D0);
    repeat (3) @(negedge clk);
    pwr_dn_n = 1'b0; #1;
    chk("R11 abort raised", eng_abort, 1);
    @(negedge clk);
    chk("R11 abort one cycle", eng_abort, 0);
    chk("R11 ready after abort", ready, 1);
    pwr_dn_n = 1'b1;
    @(negedge clk);
    chk("R11 array mode after abort", rd_sel, 0);
    rd(s); chk("R11 status cleared", s, 8'h80);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule